// File: doc/BRIEF.md
# Byte Command Queue with Software Readback

This block holds the command bytes that a flash controller's execution engine works through. Software loads commands one 64-bit word at a time, eight command bytes per write. Sequences shorter than eight bytes are padded with idle command bytes. The execution engine removes the bytes one per pop, lowest byte of each word first. The block reports the number of free bytes and keeps sticky event flags for empty, full, overflow and readback completion. An interrupt line combines those flags under a per-flag enable mask.

A mode input selects the capacity: a small queue, or a large queue used once boot has finished. Software can read the queued words back without consuming them. It starts a readback, and the block then places each stored word in turn into a readback register and raises a valid bit. The valid bit clears when software acknowledges the read. Execution is frozen while a readback is running. A flush input and a rising edge on the mode input both empty the queue.

Top module: `cmd_byte_fifo`

## Requirements
- R1: After reset the queue is empty: `exec_avail`=0, `free_bytes`=256 with `large_mode`=0, `flags`=0, `irq`=0, `rb_active`=0 and `rb_valid`=0.
- R2: An accepted write stores 8 bytes. Bytes leave on `exec_byte` in write order, and within a word bits [7:0] come first and bits [63:56] last. `free_bytes` always equals the capacity minus the stored bytes, or 0 if the stored bytes exceed the capacity.
- R3: The capacity is 256 bytes when `large_mode`=0 and 1536 bytes when it is 1. A write is accepted only when `free_bytes` is at least 8. Any other write is dropped and sets the overflow flag, `flags[2]`.
- R4: The full flag `flags[1]` sets when an accepted write leaves fewer than 8 free bytes. The empty flag `flags[0]` sets when a pop removes the last stored byte and no write lands in the same cycle.
- R5: A write and a pop in the same cycle change `free_bytes` by their net effect, which is -7.
- R6: `exec_avail` is 1 only when bytes are stored and no readback is running. `exec_pop` while `exec_avail`=0 removes nothing.
- R7: `rb_start` starts a readback. From the next cycle on, whenever `rb_valid`=0, the next stored word is loaded into `cmd_rd_data` and `rb_valid` is set. Words are loaded from the word holding the next byte to execute through to the newest word. `cmd_rd_ack` clears `rb_valid`. A readback does not consume any bytes.
- R8: In the cycle the last word is loaded, the done flag `flags[3]` sets and `rb_active` clears. If the queue is empty when the readback starts, this happens one cycle after `rb_start`.
- R9: A command write clears `rb_active` without setting the done flag. The written word is still stored if there is room.
- R10: `flush_req` empties the queue. A 0-to-1 change of `large_mode` also empties it. A 1-to-0 change does not.
- R11: The flags are sticky. Writing 1 to a bit of `flag_clr` clears that flag, but an event in the same cycle wins. `irq` is the OR of `flags & int_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr_en | input | 1 | Software write of one command word |
| cmd_wr_data | input | 64 | Eight command bytes, byte 0 in bits [7:0] |
| cmd_rd_ack | input | 1 | Software has read `cmd_rd_data`; clears valid |
| cmd_rd_data | output | 64 | Word captured during readback |
| rb_start | input | 1 | Start a readback |
| rb_active | output | 1 | Readback running |
| rb_valid | output | 1 | `cmd_rd_data` holds an unread word |
| flush_req | input | 1 | Empty the queue |
| large_mode | input | 1 | 0: small capacity, 1: large capacity |
| exec_pop | input | 1 | Execution side takes one byte |
| exec_avail | output | 1 | A byte is offered to execution |
| exec_byte | output | 8 | Next command byte |
| free_bytes | output | 11 | Unfilled bytes |
| flag_clr | input | 4 | Write-1-to-clear for the flags |
| int_en | input | 4 | Per-flag interrupt enable |
| flags | output | 4 | [0] empty, [1] full, [2] overflow, [3] readback done |
| irq | output | 1 | Masked OR of the flags |

## Verification
The queue is exercised under several traffic patterns, and each one separates a different class of fault:
- Writes followed by a long run of pops separate byte-order faults from pointer faults.
- Filling the small queue and then the large queue to the limit, with one extra write each time, separates capacity and full-threshold errors from overflow handling.
- Writes that land in the same cycle as a pop expose free-count update mistakes.
- Readbacks are run over an empty queue, over a partly consumed head word, and over a full large queue whose tail has wrapped. A readback cut short by a write is also run. These show whether cursor wrap, done timing and the execution freeze are correct.
- Mode toggles in both directions and flushes confirm that only the rising edge and the flush empty the queue.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int WORD_BYTES = 8;
  localparam int NUM_FLAGS  = 4;
  localparam int FLG_EMPTY  = 0;
  localparam int FLG_FULL   = 1;
  localparam int FLG_OVF    = 2;
  localparam int FLG_DONE   = 3;
endpackage

// File: rtl/cmdq_store.sv
// Word-wide storage with a byte cursor into the head word.
module cmdq_store #(
  parameter int DEPTH_W = 192,
  parameter int PTR_W   = 8,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [63:0]      push_word,
  input  logic             pop,
  input  logic [PTR_W-1:0] rd_idx,
  output logic [63:0]      rd_word,
  output logic [7:0]       head_byte,
  output logic [PTR_W-1:0] head_idx,
  output logic [CNT_W-1:0] word_cnt,
  output logic [2:0]       head_off
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH_W - 1);

  logic [63:0]      mem [DEPTH_W];
  logic [PTR_W-1:0] head_q, head_n, tail_q, tail_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [2:0]       off_q, off_n;
  logic             word_done;
  logic [63:0]      head_word;

  assign word_done = pop && (off_q == 3'd7);

  always_comb begin
    head_n = head_q;
    tail_n = tail_q;
    off_n  = off_q;
    cnt_n  = cnt_q;
    if (clear) begin
      head_n = '0;
      tail_n = '0;
      off_n  = '0;
      cnt_n  = '0;
    end else begin
      if (pop) begin
        off_n = off_q + 3'd1;
        if (word_done) head_n = (head_q == LAST) ? '0 : head_q + 1'b1;
      end
      if (push) tail_n = (tail_q == LAST) ? '0 : tail_q + 1'b1;
      cnt_n = cnt_q + CNT_W'(push) - CNT_W'(word_done);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      off_q  <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_n;
      tail_q <= tail_n;
      off_q  <= off_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clear) mem[tail_q] <= push_word;
  end

  assign head_word = mem[head_q];
  assign head_byte = head_word[{off_q, 3'b000} +: 8];
  assign rd_word   = mem[rd_idx];
  assign head_idx  = head_q;
  assign word_cnt  = cnt_q;
  assign head_off  = off_q;
endmodule

// File: rtl/cmdq_readback.sv
// Walks stored words from the head word to the newest without consuming them.
module cmdq_readback #(
  parameter int DEPTH_W = 192,
  parameter int PTR_W   = 8,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             ack,
  input  logic [PTR_W-1:0] head_idx,
  input  logic [CNT_W-1:0] word_cnt,
  input  logic [63:0]      rd_word,
  output logic [PTR_W-1:0] cursor,
  output logic [63:0]      data,
  output logic             active,
  output logic             valid,
  output logic             done_evt
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH_W - 1);

  logic             act_q, act_n, val_q, val_n;
  logic [63:0]      dat_q, dat_n;
  logic [PTR_W-1:0] cur_q, cur_n;
  logic [CNT_W-1:0] rem_q, rem_n;

  always_comb begin
    act_n    = act_q;
    val_n    = val_q;
    dat_n    = dat_q;
    cur_n    = cur_q;
    rem_n    = rem_q;
    done_evt = 1'b0;
    if (ack) val_n = 1'b0;
    if (abort) begin
      act_n = 1'b0;
    end else if (start && !act_q) begin
      act_n = 1'b1;
      cur_n = head_idx;
      rem_n = word_cnt;
    end else if (act_q && !val_q) begin
      if (rem_q == '0) begin
        done_evt = 1'b1;
        act_n    = 1'b0;
      end else begin
        dat_n = rd_word;
        val_n = 1'b1;
        cur_n = (cur_q == LAST) ? '0 : cur_q + 1'b1;
        rem_n = rem_q - 1'b1;
        if (rem_q == CNT_W'(1)) begin
          done_evt = 1'b1;
          act_n    = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      val_q <= 1'b0;
      dat_q <= '0;
      cur_q <= '0;
      rem_q <= '0;
    end else begin
      act_q <= act_n;
      val_q <= val_n;
      dat_q <= dat_n;
      cur_q <= cur_n;
      rem_q <= rem_n;
    end
  end

  assign cursor = cur_q;
  assign data   = dat_q;
  assign active = act_q;
  assign valid  = val_q;
endmodule

// File: rtl/cmd_byte_fifo.sv
module cmd_byte_fifo
  import cmdq_pkg::*;
#(
  parameter int SMALL_BYTES = 256,
  parameter int LARGE_BYTES = 1536
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr_en,
  input  logic [63:0] cmd_wr_data,
  input  logic        cmd_rd_ack,
  output logic [63:0] cmd_rd_data,
  input  logic        rb_start,
  output logic        rb_active,
  output logic        rb_valid,
  input  logic        flush_req,
  input  logic        large_mode,
  input  logic        exec_pop,
  output logic        exec_avail,
  output logic [7:0]  exec_byte,
  output logic [10:0] free_bytes,
  input  logic [3:0]  flag_clr,
  input  logic [3:0]  int_en,
  output logic [3:0]  flags,
  output logic        irq
);
  localparam int DEPTH_W = LARGE_BYTES / WORD_BYTES;
  localparam int PTR_W   = $clog2(DEPTH_W);
  localparam int CNT_W   = $clog2(DEPTH_W + 1);
  localparam int FREE_W  = $clog2(LARGE_BYTES + 1);

  logic [PTR_W-1:0]     head_idx, cursor;
  logic [CNT_W-1:0]     word_cnt;
  logic [2:0]           head_off;
  logic [63:0]          rd_word;
  logic [FREE_W-1:0]    cap, used, free_now;
  logic                 large_q, mode_rise, clr_fifo;
  logic                 can_push, push, pop, done_evt;
  logic [NUM_FLAGS-1:0] flag_set, flags_q, flags_n;

  assign cap      = large_mode ? FREE_W'(LARGE_BYTES) : FREE_W'(SMALL_BYTES);
  assign used     = FREE_W'({word_cnt, 3'b000}) - FREE_W'(head_off);
  assign free_now = (used > cap) ? '0 : cap - used;

  assign mode_rise  = large_mode && !large_q;
  assign clr_fifo   = flush_req || mode_rise;
  assign can_push   = free_now >= FREE_W'(WORD_BYTES);
  assign push       = cmd_wr_en && can_push && !clr_fifo;
  assign exec_avail = (word_cnt != '0) && !rb_active;
  assign pop        = exec_pop && exec_avail;

  cmdq_store #(.DEPTH_W(DEPTH_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clr_fifo),
    .push     (push),
    .push_word(cmd_wr_data),
    .pop      (pop),
    .rd_idx   (cursor),
    .rd_word  (rd_word),
    .head_byte(exec_byte),
    .head_idx (head_idx),
    .word_cnt (word_cnt),
    .head_off (head_off)
  );

  cmdq_readback #(.DEPTH_W(DEPTH_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_rb (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (rb_start),
    .abort   (cmd_wr_en || clr_fifo),
    .ack     (cmd_rd_ack),
    .head_idx(head_idx),
    .word_cnt(word_cnt),
    .rd_word (rd_word),
    .cursor  (cursor),
    .data    (cmd_rd_data),
    .active  (rb_active),
    .valid   (rb_valid),
    .done_evt(done_evt)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[FLG_EMPTY] = pop && !push && (used == FREE_W'(1));
    flag_set[FLG_FULL]  = push && ((FREE_W+1)'(free_now) + (FREE_W+1)'(pop) < (FREE_W+1)'(16));
    flag_set[FLG_OVF]   = cmd_wr_en && !can_push;
    flag_set[FLG_DONE]  = done_evt;
    flags_n             = (flags_q & ~flag_clr) | flag_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      large_q <= 1'b0;
    end else begin
      flags_q <= flags_n;
      large_q <= large_mode;
    end
  end

  assign free_bytes = free_now;
  assign flags      = flags_q;
  assign irq        = |(flags_q & int_en);
endmodule

// File: rtl/cmd_byte_fifo_chk.sv
module cmd_byte_fifo_chk #(
  parameter int SMALL_BYTES = 256,
  parameter int LARGE_BYTES = 1536
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr_en,
  input logic        cmd_rd_ack,
  input logic        rb_active,
  input logic        rb_valid,
  input logic        flush_req,
  input logic        large_mode,
  input logic        exec_avail,
  input logic [10:0] free_bytes,
  input logic [3:0]  flags,
  input logic [3:0]  flag_clr
);
  assert_free_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    free_bytes <= (large_mode ? 11'(LARGE_BYTES) : 11'(SMALL_BYTES)));

  assert_exec_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rb_active |-> !exec_avail);

  assert_valid_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && !cmd_rd_ack) |=> rb_valid);

  assert_write_cancels_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_en |=> !rb_active);

  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !exec_avail);

  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[2] && !flag_clr[2]) |=> flags[2]);
endmodule

bind cmd_byte_fifo cmd_byte_fifo_chk #(.SMALL_BYTES(SMALL_BYTES), .LARGE_BYTES(LARGE_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_wr_en (cmd_wr_en),
  .cmd_rd_ack(cmd_rd_ack),
  .rb_active (rb_active),
  .rb_valid  (rb_valid),
  .flush_req (flush_req),
  .large_mode(large_mode),
  .exec_avail(exec_avail),
  .free_bytes(free_bytes),
  .flags     (flags),
  .flag_clr  (flag_clr)
);

// File: tb/cmd_byte_fifo_tb.sv
`timescale 1ns/1ps
module cmd_byte_fifo_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr_en = 1'b0, cmd_rd_ack = 1'b0, rb_start = 1'b0;
  logic        flush_req = 1'b0, large_mode = 1'b0, exec_pop = 1'b0;
  logic [63:0] cmd_wr_data = '0;
  logic [3:0]  flag_clr = '0, int_en = '0;
  logic [63:0] cmd_rd_data;
  logic        rb_active, rb_valid, exec_avail, irq;
  logic [7:0]  exec_byte;
  logic [10:0] free_bytes;
  logic [3:0]  flags;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  cmd_byte_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
    .cmd_rd_ack(cmd_rd_ack), .cmd_rd_data(cmd_rd_data), .rb_start(rb_start),
    .rb_active(rb_active), .rb_valid(rb_valid), .flush_req(flush_req),
    .large_mode(large_mode), .exec_pop(exec_pop), .exec_avail(exec_avail),
    .exec_byte(exec_byte), .free_bytes(free_bytes), .flag_clr(flag_clr),
    .int_en(int_en), .flags(flags), .irq(irq)
  );

  // Behavioural reference
  logic [63:0] wq[$];
  int          m_off = 0;
  logic [3:0]  m_flags = '0;
  bit          m_act = 0, m_val = 0, m_lq = 0;
  logic [63:0] m_data = '0;
  int          m_rem = 0, m_idx = 0;

  function automatic int m_stored();
    return wq.size() * 8 - m_off;
  endfunction

  function automatic int m_free();
    int cap = large_mode ? 1536 : 256;
    return (m_stored() > cap) ? 0 : cap - m_stored();
  endfunction

  task automatic model_step();
    int  fr = m_free();
    bit  rise = large_mode && !m_lq;
    bit  clr = flush_req || rise;
    bit  can = fr >= 8;
    bit  push = cmd_wr_en && can && !clr;
    bit  avail = (wq.size() != 0) && !m_act;
    bit  pop = exec_pop && avail;
    logic [3:0] set = '0;
    bit  nact = m_act, nval = m_val;
    set[0] = pop && !push && (m_stored() == 1);
    set[1] = push && (fr - 8 + int'(pop) < 8);
    set[2] = cmd_wr_en && !can;
    if (cmd_rd_ack) nval = 0;
    if (cmd_wr_en || clr) nact = 0;
    else if (rb_start && !m_act) begin
      nact = 1; m_rem = wq.size(); m_idx = 0;
    end else if (m_act && !m_val) begin
      if (m_rem == 0) begin set[3] = 1; nact = 0; end
      else begin
        m_data = wq[m_idx]; nval = 1; m_idx++; m_rem--;
        if (m_rem == 0) begin set[3] = 1; nact = 0; end
      end
    end
    m_act = nact; m_val = nval;
    if (clr) begin
      wq.delete(); m_off = 0;
    end else begin
      if (pop) begin
        m_off++;
        if (m_off == 8) begin void'(wq.pop_front()); m_off = 0; end
      end
      if (push) wq.push_back(cmd_wr_data);
    end
    m_flags = (m_flags & ~flag_clr) | set;
    m_lq = large_mode;
  endtask

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit av = (wq.size() != 0) && !m_act;
    vectors++;
    chk(64'(free_bytes), 64'(m_free()), "R2 free byte count");
    chk(64'(exec_avail), 64'(av), "R6 exec_avail");
    if (av) chk(64'(exec_byte), 64'(wq[0][m_off*8 +: 8]), "R2 byte order");
    chk(64'(flags[0]), 64'(m_flags[0]), "R4 empty flag");
    chk(64'(flags[1]), 64'(m_flags[1]), "R4 full flag");
    chk(64'(flags[2]), 64'(m_flags[2]), "R3 overflow flag");
    chk(64'(flags[3]), 64'(m_flags[3]), "R8 done flag");
    chk(64'(irq), 64'(|(m_flags & int_en)), "R11 irq");
    chk(64'(rb_active), 64'(m_act), "R7 rb_active");
    chk(64'(rb_valid), 64'(m_val), "R7 rb_valid");
    if (m_val) chk(cmd_rd_data, m_data, "R7 readback data");
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    cmd_wr_en = 0; cmd_rd_ack = 0; rb_start = 0;
    flush_req = 0; exec_pop = 0; flag_clr = '0;
  endtask

  function automatic logic [63:0] pat(input int i);
    return {8{8'(i * 37 + 5)}} ^ 64'h0706050403020100;
  endfunction

  task automatic wr(input int i);
    cmd_wr_en = 1; cmd_wr_data = pat(i); tick();
  endtask

  task automatic pops(input int n);
    for (int k = 0; k < n; k++) begin exec_pop = 1; tick(); end
  endtask

  task automatic readback();
    rb_start = 1; exec_pop = 1; tick();
    for (int k = 0; k < 400; k++) begin
      if (!rb_active && !rb_valid) break;
      exec_pop = rb_active;      // R6: pops attempted while frozen
      if (rb_valid) cmd_rd_ack = 1;
      tick();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    vectors++;
    if (free_bytes !== 11'd256 || exec_avail !== 1'b0 || flags !== 4'd0 || irq !== 1'b0 ||
        rb_active !== 1'b0 || rb_valid !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 reset: actual free=%0d flags=%0h expected free=256 flags=0", free_bytes, flags);
    end
    compare();

    // R2 ordering over several words, R4 empty event
    for (int i = 0; i < 3; i++) wr(i);
    pops(24);
    pops(2);
    // R11 write-1-to-clear and masked interrupt
    int_en = 4'b0001; tick();
    flag_clr = 4'b0001; tick();
    int_en = 4'b1111; tick();

    // R3/R4 fill small capacity, full then overflow
    for (int i = 0; i < 32; i++) wr(10 + i);
    wr(99);
    flag_clr = 4'b0110; cmd_wr_en = 1; cmd_wr_data = pat(98); tick(); // set wins over clear
    pops(3);
    // R5 same-cycle write and pop
    cmd_wr_en = 1; cmd_wr_data = pat(50); exec_pop = 1; tick();
    pops(5);
    cmd_wr_en = 1; cmd_wr_data = pat(51); exec_pop = 1; tick();
    // R7/R8 readback with partly consumed head word
    readback();
    pops(20);
    // R10 flush
    flush_req = 1; tick();
    // R8 readback of empty queue
    readback();
    // R9 write aborts readback
    for (int i = 0; i < 4; i++) wr(60 + i);
    rb_start = 1; tick();
    tick();
    cmd_rd_ack = 1; tick();
    wr(70);
    cmd_rd_ack = 1; tick();
    pops(9);

    // R10 rising large_mode empties, falling does not
    large_mode = 1; tick();
    for (int i = 0; i < 40; i++) wr(100 + i);
    large_mode = 0; tick();
    wr(200);
    pops(4);
    large_mode = 1; tick();
    // R3 large capacity fill, wrap, full readback
    flag_clr = 4'hF; tick();
    for (int i = 0; i < 192; i++) wr(300 + i);
    wr(600);
    pops(16);
    wr(601); wr(602);
    readback();
    pops(40);
    flush_req = 1; tick();
    tick();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule